// File: doc/BRIEF.md
# Serial memory status and write-protect unit

This block keeps the status byte of a byte-addressed serial memory and decides, command by command, whether a write may go ahead. Upstream logic has already decoded the serial command. It presents single-cycle strobes for:
- enabling writes and disabling writes,
- loading the status byte,
- snapshotting the status byte for readback,
- writing the array at a 17-bit address,
- reading the array.

The block also receives the level of the protect pin and a busy flag from the write engine. It answers every array write and every status write with a grant or a deny strobe in the same cycle.

Permission comes from several inputs taken together: the write-enable latch, the protect pin, a pin-enable bit and a two-bit region code that fences off a quarter, half or all of the array. An identification-page select latch sends accesses to a separate page instead of the main array. A lock bit makes that page read-only for good. A single status write that tries to raise both the select latch and the lock leaves both unchanged. The nonvolatile bits are plain registers here. A soft reset does not touch them.

Top module: `spStatusUnit`

## Requirements
- R1: The status byte is {bit7 pin-protect enable, bit6 ID-page select, bit5 constant 0, bit4 ID-page lock, bits3:2 region code, bit1 write-enable latch, bit0 busy}. Bit 0 shows busyIn and no status write can change it.
- R2: The write-enable latch rises on an enable-write strobe and falls on a disable-write strobe. It also falls when busy goes from 1 to 0, and when an array or status write is denied. A clear wins over a set in the same cycle.
- R3: While the write-enable latch is 0, every array write and every status write is denied, and no status bit changes.
- R4: The region code protects main-array addresses as follows: 00 protects none, 01 protects 18000h–1FFFFh, 10 protects 10000h–1FFFFh, 11 protects all addresses. A write to a protected address is denied.
- R5: When the latch is 1, pin-protect enable is 1 and the protect pin is low, a status write is denied. Array writes to unprotected addresses are still granted.
- R6: When the latch is 1 and either pin-protect enable is 0 or the protect pin is high, a status write is granted. Protected regions stay read-only.
- R7: The ID-page select (output idPageSel, status bit 6) clears on any of these events: when busy falls after a granted array write, on an array read, or on a denied array write.
- R8: A granted status write whose data has both bit 6 and bit 4 set changes neither the ID-page select nor the lock.
- R9: Once the lock is 1, it stays 1. While the ID-page select is 1 and the lock is 1, array writes are denied.
- R10: While busy is 1, every command except status readback is ignored: no grant, no deny and no state change.
- R11: Reset clears the write-enable latch and the ID-page select. Pin-protect enable, lock and region code keep their values across reset.
- R12: A granted status write loads only bits 7, 6, 4, 3 and 2. statusOut is 0 after reset and takes a snapshot of the status byte one clock after a read-status strobe, including while busy.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low soft reset (volatile bits only) |
| cmdWrEn | input | 1 | Enable-write strobe |
| cmdWrDis | input | 1 | Disable-write strobe |
| cmdSrWrite | input | 1 | Status-write strobe |
| srData | input | 8 | Data byte for a status write |
| cmdSrRead | input | 1 | Status readback strobe |
| cmdArrWrite | input | 1 | Array-write strobe |
| arrAddr | input | ADDR_W | Array byte address |
| cmdArrRead | input | 1 | Array-read strobe |
| wpPinN | input | 1 | Protect pin level (low = protect) |
| busyIn | input | 1 | Write engine busy flag |
| statusOut | output | 8 | Status byte snapshot |
| arrWrGrant | output | 1 | Array write granted |
| arrWrDeny | output | 1 | Array write denied |
| srWrGrant | output | 1 | Status write granted |
| srWrDeny | output | 1 | Status write denied |
| idPageSel | output | 1 | 1 selects the identification page, 0 the main array |

## Verification
The bench builds the unit with ADDR_W = 17. At that width the region edges 0FFFFh/10000h and 17FFFh/18000h, and the top address 1FFFFh, can be driven directly. This lets each region code be probed on both sides of its boundary. The vector walk places busy pulses between commands, so that latch clearing on busy fall and bit 0 during busy are both observed through readback.

// File: rtl/spStatusPkg.sv
package spStatusPkg;
  localparam int SR_W      = 8;
  localparam int BIT_WPEN  = 7;
  localparam int BIT_IDSEL = 6;
  localparam int BIT_LOCK  = 4;
  localparam int BIT_BPHI  = 3;
  localparam int BIT_BPLO  = 2;

  typedef enum logic [1:0] {
    REGION_NONE    = 2'b00,
    REGION_QUARTER = 2'b01,
    REGION_HALF    = 2'b10,
    REGION_ALL     = 2'b11
  } regionT;

  typedef struct packed {
    logic setWel;
    logic clrWel;
    logic loadSr;
    logic clrIdSel;
    logic setPending;
    logic clrPending;
    logic snapStatus;
  } strobeT;
endpackage

// File: rtl/spStatusCtrl.sv
module spStatusCtrl
  import spStatusPkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdWrEn,
  input  logic              cmdWrDis,
  input  logic              cmdSrWrite,
  input  logic              cmdSrRead,
  input  logic              cmdArrWrite,
  input  logic [ADDR_W-1:0] arrAddr,
  input  logic              cmdArrRead,
  input  logic              wpPinN,
  input  logic              busyIn,
  input  logic              welQ,
  input  logic              wpenQ,
  input  logic              idSelQ,
  input  logic              lockQ,
  input  regionT            bpQ,
  input  logic              pendingQ,
  output strobeT            strb,
  output logic              arrWrGrant,
  output logic              arrWrDeny,
  output logic              srWrGrant,
  output logic              srWrDeny
);
  localparam int TOP = ADDR_W - 1;

  logic busyPrev;
  logic busyFall;
  logic idle;
  logic regionHit;
  logic addrBlocked;
  logic pinLock;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busyPrev <= 1'b0;
    else       busyPrev <= busyIn;
  end

  assign busyFall = busyPrev & ~busyIn;
  assign idle     = ~busyIn;

  always_comb begin
    unique case (bpQ)
      REGION_NONE:    regionHit = 1'b0;
      REGION_QUARTER: regionHit = arrAddr[TOP] & arrAddr[TOP-1];
      REGION_HALF:    regionHit = arrAddr[TOP];
      default:        regionHit = 1'b1;
    endcase
  end

  assign addrBlocked = idSelQ ? lockQ : regionHit;
  assign pinLock     = wpenQ & ~wpPinN;

  assign arrWrGrant = cmdArrWrite & idle & welQ & ~addrBlocked;
  assign arrWrDeny  = cmdArrWrite & idle & ~arrWrGrant;
  assign srWrGrant  = cmdSrWrite & idle & welQ & ~pinLock;
  assign srWrDeny   = cmdSrWrite & idle & ~srWrGrant;

  always_comb begin
    strb            = '0;
    strb.setWel     = cmdWrEn & idle;
    strb.clrWel     = (cmdWrDis & idle) | busyFall | arrWrDeny | srWrDeny;
    strb.loadSr     = srWrGrant;
    strb.clrIdSel   = arrWrDeny | (cmdArrRead & idle) | (busyFall & pendingQ);
    strb.setPending = arrWrGrant;
    strb.clrPending = busyFall;
    strb.snapStatus = cmdSrRead;
  end

  // R10: nothing is answered while the write engine runs
  a_r10_busy_quiet: assert property (@(posedge clk) disable iff (!rstN)
    busyIn |-> !(arrWrGrant || arrWrDeny || srWrGrant || srWrDeny));

  // R5: pin protection blocks status writes
  a_r5_pin_blocks_sr: assert property (@(posedge clk) disable iff (!rstN)
    (wpenQ && !wpPinN) |-> !srWrGrant);

  // R3: no grant without the enable latch
  a_r3_grant_needs_wel: assert property (@(posedge clk) disable iff (!rstN)
    (arrWrGrant || srWrGrant) |-> welQ);

  // R2: grant and deny never together
  a_r2_answer_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({arrWrGrant, arrWrDeny}) && $onehot0({srWrGrant, srWrDeny}));
endmodule

// File: rtl/spStatusRegs.sv
module spStatusRegs
  import spStatusPkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  strobeT          strb,
  input  logic [SR_W-1:0] srData,
  input  logic            busyIn,
  output logic            welQ,
  output logic            wpenQ,
  output logic            idSelQ,
  output logic            lockQ,
  output regionT          bpQ,
  output logic            pendingQ,
  output logic [SR_W-1:0] statusOut
);
  // nonvolatile bits: power-up value only, untouched by soft reset
  logic   wpenR = 1'b0;
  logic   lockR = 1'b0;
  regionT bpR   = REGION_NONE;

  logic jointSet;
  logic [SR_W-1:0] statusNow;

  assign jointSet = srData[BIT_IDSEL] & srData[BIT_LOCK];

  always_ff @(posedge clk) begin
    if (strb.loadSr) begin
      wpenR <= srData[BIT_WPEN];
      bpR   <= regionT'(srData[BIT_BPHI:BIT_BPLO]);
      if (!jointSet) lockR <= lockR | srData[BIT_LOCK];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      welQ     <= 1'b0;
      idSelQ   <= 1'b0;
      pendingQ <= 1'b0;
    end else begin
      if (strb.clrWel)      welQ <= 1'b0;
      else if (strb.setWel) welQ <= 1'b1;

      if (strb.loadSr && !jointSet) idSelQ <= srData[BIT_IDSEL];
      else if (strb.clrIdSel)       idSelQ <= 1'b0;

      if (strb.setPending)      pendingQ <= 1'b1;
      else if (strb.clrPending) pendingQ <= 1'b0;
    end
  end

  assign statusNow = {wpenR, idSelQ, 1'b0, lockR, bpR, welQ, busyIn};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               statusOut <= '0;
    else if (strb.snapStatus) statusOut <= statusNow;
  end

  assign wpenQ = wpenR;
  assign lockQ = lockR;
  assign bpQ   = bpR;

  // R3: protection bits only move while the latch is set
  a_r3_nv_hold_without_wel: assert property (@(posedge clk) disable iff (!rstN)
    !welQ |=> $stable({wpenR, lockR, bpR}));

  // R9: lock never falls
  a_r9_lock_sticky: assert property (@(posedge clk) disable iff (!rstN)
    lockR |=> lockR);

  // R8: select and lock never rise together
  a_r8_no_joint_rise: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lockR) |-> !$rose(idSelQ));

  // R2: latch is clear after busy falls
  a_r2_fall_clears_wel: assert property (@(posedge clk) disable iff (!rstN)
    (!busyIn && $past(busyIn)) |=> !welQ);
endmodule

// File: rtl/spStatusUnit.sv
module spStatusUnit
  import spStatusPkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdWrEn,
  input  logic              cmdWrDis,
  input  logic              cmdSrWrite,
  input  logic [7:0]        srData,
  input  logic              cmdSrRead,
  input  logic              cmdArrWrite,
  input  logic [ADDR_W-1:0] arrAddr,
  input  logic              cmdArrRead,
  input  logic              wpPinN,
  input  logic              busyIn,
  output logic [7:0]        statusOut,
  output logic              arrWrGrant,
  output logic              arrWrDeny,
  output logic              srWrGrant,
  output logic              srWrDeny,
  output logic              idPageSel
);
  strobeT strb;
  logic   welQ, wpenQ, idSelQ, lockQ, pendingQ;
  regionT bpQ;

  spStatusCtrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .clk(clk), .rstN(rstN),
    .cmdWrEn(cmdWrEn), .cmdWrDis(cmdWrDis), .cmdSrWrite(cmdSrWrite),
    .cmdSrRead(cmdSrRead), .cmdArrWrite(cmdArrWrite), .arrAddr(arrAddr),
    .cmdArrRead(cmdArrRead), .wpPinN(wpPinN), .busyIn(busyIn),
    .welQ(welQ), .wpenQ(wpenQ), .idSelQ(idSelQ), .lockQ(lockQ), .bpQ(bpQ),
    .pendingQ(pendingQ), .strb(strb),
    .arrWrGrant(arrWrGrant), .arrWrDeny(arrWrDeny),
    .srWrGrant(srWrGrant), .srWrDeny(srWrDeny)
  );

  spStatusRegs i_regs (
    .clk(clk), .rstN(rstN), .strb(strb), .srData(srData), .busyIn(busyIn),
    .welQ(welQ), .wpenQ(wpenQ), .idSelQ(idSelQ), .lockQ(lockQ), .bpQ(bpQ),
    .pendingQ(pendingQ), .statusOut(statusOut)
  );

  assign idPageSel = idSelQ;
endmodule

// File: tb/test_spStatusUnit.sv
module test_spStatusUnit;
  localparam int ADDR_W = 17;

  typedef struct packed {
    logic [2:0]  op;    // 0 idle 1 wren 2 wrdis 3 srwrite 4 arrwrite 5 arrread
    logic [7:0]  data;
    logic [16:0] addr;
    logic        pin;
    logic        busy;
    logic [3:0]  ans;   // {arrGrant, arrDeny, srGrant, srDeny}
    logic [7:0]  stat;  // expected snapshot after the step
  } vecT;

  localparam int NV = 73;
  localparam vecT VECS [NV] = '{
    '{3'd4,8'h00,17'h00000,1'b1,1'b0,4'b0100,8'h00}, // R3
    '{3'd1,8'h00,17'h00000,1'b1,1'b0,4'b0000,8'h02}, // R2
    '{3'd4,8'h00,17'h1FFFF,1'b1,1'b0,4'b1000,8'h02}, // R4 none
    '{3'd0,8'h00,17'h00000,1'b1,1'b1,4'b0000,8'h03}, // R1
    '{3'd0,8'h00,17'h00000,1'b1,1'b0,4'b0000,8'h00}, // R2 fall
    '{3'd1,8'h00,17'h00000,1'b1,1'b0,4'b0000,8'h02},
    '{3'd3,8'h88,17'h00000,1'b1,1'b0,4'b0010,8'h8A}, // R6
    '{3'd0,8'h00,17'h00000,1'b1,1'b1,4'b0000,8'h8B},
    '{3'd0,8'h00,17'h00000,1'b1,1'b0,4'b0000,8'h88},
    '{3'd1,8'h00,17'h00000,1'b1,1'b0,4'b0000,8'h8A},
    '{3'd4,8'h00,17'h10000,1'b1,1'b0,4'b0100,8'h88}, // R4 half
    '{3'd1,8'h00,17'h00000,1'b1,1'b0,4'b0000,8'h8A},
    '{3'd4,8'h00,17'h0FFFF,1'b1,1'b0,4'b1000,8'h8A}, // R4 half edge
    '{3'd0,8'h00,17'h00000,1'b1,1'b1,4'b0000,8'h8B},
    '{3'd0,8'h00,17'h00000,1'b1,1'b0,4'b0000,8'h88},
    '{3'd1,8'h00,17'h00000,1'b0,1'b0,4'b0000,8'h8A},
    '{3'd3,8'h00,17'h00000,1'b0,1'b0,4'b0001,8'h88}, // R5
    '{3'd1,8'h00,17'h00000,1'b0,1'b0,4'b0000,8'h8A},
    '{3'd4,8'h00,17'h00100,1'b0,1'b0,4'b1000,8'h8A}, // R5 array ok
    '{3'd0,8'h00,17'h00000,1'b1,1'b1,4'b0000,8'h8B},
    '{3'd0,8'h00,17'h00000,1'b1,1'b0,4'b0000,8'h88},
    '{3'd1,8'h00,17'h00000,1'b1,1'b0,4'b0000,8'h8A},
    '{3'd2,8'h00,17'h00000,1'b1,1'b0,4'b0000,8'h88}, // R2 wrdis
    '{3'd1,8'h00,17'h00000,1'b1,1'b1,4'b0000,8'h89}, // R10
    '{3'd0,8'h00,17'h00000,1'b1,1'b0,4'b0000,8'h88},
    '{3'd1,8'h00,17'h00000,1'b1,1'b0,4'b0000,8'h8A},
    '{3'd3,8'h04,17'h00000,1'b1,1'b0,4'b0010,8'h06}, // R6 pin high
    '{3'd0,8'h00,17'h00000,1'b1,1'b1,4'b0000,8'h07},
    '{3'd0,8'h00,17'h00000,1'b1,1'b0,4'b0000,8'h04},
    '{3'd1,8'h00,17'h00000,1'b1,1'b0,4'b0000,8'h06},
    '{3'd4,8'h00,17'h17FFF,1'b1,1'b0,4'b1000,8'h06}, // R4 quarter edge
    '{3'd0,8'h00,17'h00000,1'b1,1'b1,4'b0000,8'h07},
    '{3'd0,8'h00,17'h00000,1'b1,1'b0,4'b0000,8'h04},
    '{3'd1,8'h00,17'h00000,1'b1,1'b0,4'b0000,8'h06},
    '{3'd4,8'h00,17'h18000,1'b1,1'b0,4'b0100,8'h04}, // R4 quarter
    '{3'd1,8'h00,17'h00000,1'b1,1'b0,4'b0000,8'h06},
    '{3'd3,8'h50,17'h00000,1'b0,1'b0,4'b0010,8'h02}, // R8
    '{3'd0,8'h00,17'h00000,1'b1,1'b1,4'b0000,8'h03},
    '{3'd0,8'h00,17'h00000,1'b1,1'b0,4'b0000,8'h00},
    '{3'd1,8'h00,17'h00000,1'b1,1'b0,4'b0000,8'h02},
    '{3'd3,8'h40,17'h00000,1'b1,1'b0,4'b0010,8'h42}, // R7 select
    '{3'd0,8'h00,17'h00000,1'b1,1'b1,4'b0000,8'h43},
    '{3'd0,8'h00,17'h00000,1'b1,1'b0,4'b0000,8'h40},
    '{3'd1,8'h00,17'h00000,1'b1,1'b0,4'b0000,8'h42},
    '{3'd4,8'h00,17'h00000,1'b1,1'b0,4'b1000,8'h42},
    '{3'd0,8'h00,17'h00000,1'b1,1'b1,4'b0000,8'h43},
    '{3'd0,8'h00,17'h00000,1'b1,1'b0,4'b0000,8'h00}, // R7 write done
    '{3'd1,8'h00,17'h00000,1'b1,1'b0,4'b0000,8'h02},
    '{3'd3,8'h13,17'h00000,1'b1,1'b0,4'b0010,8'h12}, // R12 R1
    '{3'd0,8'h00,17'h00000,1'b1,1'b1,4'b0000,8'h13},
    '{3'd0,8'h00,17'h00000,1'b1,1'b0,4'b0000,8'h10},
    '{3'd1,8'h00,17'h00000,1'b1,1'b0,4'b0000,8'h12},
    '{3'd3,8'h40,17'h00000,1'b1,1'b0,4'b0010,8'h52},
    '{3'd0,8'h00,17'h00000,1'b1,1'b1,4'b0000,8'h53},
    '{3'd0,8'h00,17'h00000,1'b1,1'b0,4'b0000,8'h50},
    '{3'd1,8'h00,17'h00000,1'b1,1'b0,4'b0000,8'h52},
    '{3'd4,8'h00,17'h00000,1'b1,1'b0,4'b0100,8'h10}, // R9
    '{3'd1,8'h00,17'h00000,1'b1,1'b0,4'b0000,8'h12},
    '{3'd3,8'h00,17'h00000,1'b1,1'b0,4'b0010,8'h12}, // R9 sticky
    '{3'd0,8'h00,17'h00000,1'b1,1'b1,4'b0000,8'h13},
    '{3'd0,8'h00,17'h00000,1'b1,1'b0,4'b0000,8'h10},
    '{3'd3,8'h40,17'h00000,1'b1,1'b0,4'b0001,8'h10}, // R3
    '{3'd1,8'h00,17'h00000,1'b1,1'b0,4'b0000,8'h12},
    '{3'd3,8'h40,17'h00000,1'b1,1'b0,4'b0010,8'h52},
    '{3'd0,8'h00,17'h00000,1'b1,1'b1,4'b0000,8'h53},
    '{3'd0,8'h00,17'h00000,1'b1,1'b0,4'b0000,8'h50},
    '{3'd5,8'h00,17'h00000,1'b1,1'b0,4'b0000,8'h10}, // R7 read
    '{3'd1,8'h00,17'h00000,1'b1,1'b0,4'b0000,8'h12},
    '{3'd3,8'h0C,17'h00000,1'b1,1'b0,4'b0010,8'h1E},
    '{3'd0,8'h00,17'h00000,1'b1,1'b1,4'b0000,8'h1F},
    '{3'd0,8'h00,17'h00000,1'b1,1'b0,4'b0000,8'h1C},
    '{3'd1,8'h00,17'h00000,1'b1,1'b0,4'b0000,8'h1E},
    '{3'd4,8'h00,17'h00000,1'b1,1'b0,4'b0100,8'h1C}  // R4 all
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdWrEn = 1'b0, cmdWrDis = 1'b0, cmdSrWrite = 1'b0, cmdSrRead = 1'b0;
  logic cmdArrWrite = 1'b0, cmdArrRead = 1'b0;
  logic [7:0] srData = '0;
  logic [ADDR_W-1:0] arrAddr = '0;
  logic wpPinN = 1'b1;
  logic busyIn = 1'b0;
  logic [7:0] statusOut;
  logic arrWrGrant, arrWrDeny, srWrGrant, srWrDeny, idPageSel;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  spStatusUnit #(.ADDR_W(ADDR_W)) i_spStatusUnit (
    .clk(clk), .rstN(rstN), .cmdWrEn(cmdWrEn), .cmdWrDis(cmdWrDis),
    .cmdSrWrite(cmdSrWrite), .srData(srData), .cmdSrRead(cmdSrRead),
    .cmdArrWrite(cmdArrWrite), .arrAddr(arrAddr), .cmdArrRead(cmdArrRead),
    .wpPinN(wpPinN), .busyIn(busyIn), .statusOut(statusOut),
    .arrWrGrant(arrWrGrant), .arrWrDeny(arrWrDeny), .srWrGrant(srWrGrant),
    .srWrDeny(srWrDeny), .idPageSel(idPageSel)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clearCmds();
    cmdWrEn = 0; cmdWrDis = 0; cmdSrWrite = 0; cmdSrRead = 0;
    cmdArrWrite = 0; cmdArrRead = 0;
  endtask

  task automatic applyOp(input logic [2:0] op);
    clearCmds();
    case (op)
      3'd1: cmdWrEn = 1;
      3'd2: cmdWrDis = 1;
      3'd3: cmdSrWrite = 1;
      3'd4: cmdArrWrite = 1;
      3'd5: cmdArrRead = 1;
      default: ;
    endcase
  endtask

  task automatic readStatus(input string req, input logic [7:0] exp);
    @(negedge clk);
    clearCmds();
    cmdSrRead = 1;
    @(negedge clk);
    cmdSrRead = 0;
    #1;
    check(req, statusOut, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    #1;
    check("R12 reset snapshot", statusOut, 8'h00);
    check("R11 reset select", idPageSel, 1'b0);
    check("R11 reset answers", {arrWrGrant, arrWrDeny, srWrGrant, srWrDeny}, 4'b0000);
    readStatus("R11 reset status", 8'h00);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      srData  = VECS[i].data;
      arrAddr = VECS[i].addr;
      wpPinN  = VECS[i].pin;
      busyIn  = VECS[i].busy;
      applyOp(VECS[i].op);
      #1;
      check($sformatf("R2-step %0d answers (R3 R4 R5 R6 R9)", i),
            {arrWrGrant, arrWrDeny, srWrGrant, srWrDeny}, VECS[i].ans);
      readStatus($sformatf("R1 R12 step %0d status", i), VECS[i].stat);
      check($sformatf("R7 step %0d select", i), idPageSel, VECS[i].stat[6]);
    end

    // R10: array write ignored while busy even with the latch set
    @(negedge clk); busyIn = 0; wpPinN = 1; applyOp(3'd1);
    @(negedge clk); busyIn = 1; arrAddr = 17'h00010; applyOp(3'd4);
    #1;
    check("R10 busy array write", {arrWrGrant, arrWrDeny}, 2'b00);
    readStatus("R10 busy state kept", 8'h1F);
    @(negedge clk); busyIn = 0; clearCmds();
    readStatus("R2 fall after busy", 8'h1C);

    // R11: soft reset keeps nonvolatile bits, clears latch and select
    @(negedge clk); applyOp(3'd1);
    @(negedge clk); clearCmds(); rstN = 0;
    @(negedge clk); rstN = 1;
    #1;
    check("R11 snapshot cleared", statusOut, 8'h00);
    readStatus("R11 nv kept", 8'h1C);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule